// File: doc/BRIEF.md
# Receive Alarm Interrupt Controller

This block gathers receive-path alarm levels from eight line channels, four alarms per channel, and merges them into one shared active-low interrupt. Each alarm input is first synchronised. Any transition of a synchronised alarm latches a sticky status bit. Rising and falling transitions both count, so the interrupt reports an alarm entering and an alarm leaving.

Software resolves the source in two steps. It first reads a channel-pending register that has one bit per channel. It then reads that channel's status register. Reading a channel's status register clears it, and the interrupt releases once no enabled status remains. Each status bit has its own enable bit, and one global enable gates the output. The interrupt is given as an active-low level plus an output-enable, for an open-drain pad outside this block.

Top module: `rx_alarm_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit and the global enable are 0. irq_n is 1, irq_oe is 0, and every register reads 0.
- R2: Alarm input bit ch*4+k belongs to channel ch and alarm k. The alarm codes are k=0 loss of signal, k=1 alarm indication, k=2 pattern detect and k=3 flat signal. A 0-to-1 change of that input sets bit k of the status register of channel ch (address 2+ch). The bit becomes visible after the third rising clock edge following the change, and not before.
- R3: A 1-to-0 change of an alarm input sets its status bit in the same way as a 0-to-1 change.
- R4: A read of status register 2+ch returns the latched bits in bits 3:0 and clears them. An immediate second read returns 0.
- R5: If a status bit is cleared by a read in the same cycle as a new change of that alarm reaches it, the bit stays set.
- R6: The enable register of channel ch is at address 10+ch, bits 3:0, and 1 means enabled. A latched status bit whose enable is 0 neither pulls irq_n low nor sets the channel's pending bit. It is still latched and can still be read.
- R7: The global enable is bit 0 of address 0. While it is 0, irq_n stays 1 whatever status is pending.
- R8: Address 1 is read-only. Bit ch is 1 when channel ch has any enabled status bit set. Reading address 1 does not change it.
- R9: irq_n is 0 exactly when the global enable is 1 and some channel is pending. irq_oe is always the inverse of irq_n. Reading all pending status registers releases irq_n to 1.
- R10: Writes to address 1, to status addresses and to unmapped addresses (18 and above) change nothing. Unmapped addresses read 0.
- R11: An alarm input that holds its level sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_in | input | 32 | Asynchronous alarm levels, bit ch*4+k |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when reading a status address) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as reg_rd |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Pad output-enable, high while the interrupt is asserted |

## Verification
Directed patterns cover the cases that separate correct behaviour from plausible faults. A single rising edge checks the latency. A falling edge checks that both directions are detected. A change that coincides with a clearing read checks that the new change wins. Masked, unmasked and globally disabled alarms are checked against the interrupt and the pending register. Random sparse toggles over all 32 inputs are then mixed with random enable writes, global enable flips and clearing reads. These show that every input maps to the right channel and bit position, and that the pending register and irq_n track the enabled latched state.

// File: rtl/rx_alarm_pkg.sv
// Package: shared constants for the receive alarm interrupt controller.
// Assumes the register map starts at address 0 with control, then pending,
// then per-channel status, then per-channel enables.
package rx_alarm_pkg;
    typedef enum logic [1:0] {
        ALM_LOS  = 2'd0,
        ALM_AIS  = 2'd1,
        ALM_PATT = 2'd2,
        ALM_FLAT = 2'd3
    } alarm_kind_e;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_PEND = 1;
    localparam int unsigned STAT_BASE = 2;
endpackage

// File: rtl/alm_change_det.sv
// Module: synchronises a vector of asynchronous alarm levels and flags every
// transition as a one-cycle pulse. Assumes inputs are inactive (0) at reset.
module alm_change_det #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] change_o
);
    logic [WIDTH-1:0] sync_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    // Synchroniser chain plus one register holding the previous settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) sync_q[i] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= level_i;
            for (int i = 1; i < int'(STAGES); i++) sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Any difference between settled and previous value is a transition.
    always_comb change_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/alm_chan_status.sv
// Module: sticky status and enable bits for one channel. A clear from a read
// loses to a transition arriving in the same cycle.
module alm_chan_status #(
    parameter int unsigned NUM_ALM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ALM-1:0] change_i,
    input  logic               clr_i,
    input  logic               en_we_i,
    input  logic [NUM_ALM-1:0] en_d_i,
    output logic [NUM_ALM-1:0] status_o,
    output logic [NUM_ALM-1:0] en_o,
    output logic               pend_o
);
    logic [NUM_ALM-1:0] status_q;
    logic [NUM_ALM-1:0] en_q;

    // Latch transitions; clear on read unless a new transition arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (clr_i ? '0 : status_q) | change_i;
    end

    // Per-alarm interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_d_i;
    end

    // Channel summary: any enabled latched status.
    always_comb pend_o = |(status_q & en_q);

    assign status_o = status_q;
    assign en_o     = en_q;
endmodule

// File: rtl/alm_irq_merge.sv
// Module: combines channel summaries with the global enable into an
// active-low level and a pad output-enable.
module alm_irq_merge #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              gie_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic              irq_n_o,
    output logic              irq_oe_o
);
    logic active;

    // Interrupt active when globally enabled and any channel pending.
    always_comb begin
        active   = gie_i & (|pend_i);
        irq_n_o  = ~active;
        irq_oe_o = active;
    end
endmodule

// File: rtl/rx_alarm_irq_ctrl.sv
// Module: top of the receive alarm interrupt controller. Holds the register
// decode, the global enable and one status bank per channel.
// Assumes reads are single-cycle strobes and NUM_CH, NUM_ALM <= DATA_W.
module rx_alarm_irq_ctrl
    import rx_alarm_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned NUM_ALM     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_ALM-1:0] alarm_in,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      irq_n,
    output logic                      irq_oe
);
    localparam int unsigned N_BITS   = NUM_CH * NUM_ALM;
    localparam int unsigned EN_BASE  = STAT_BASE + NUM_CH;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND);

    logic [N_BITS-1:0] change_all;
    logic [N_BITS-1:0] status_flat;
    logic [N_BITS-1:0] en_flat;
    logic [NUM_CH-1:0] pend_vec;
    logic [NUM_CH-1:0] stat_hit;
    logic [NUM_CH-1:0] en_hit;
    logic [NUM_CH-1:0] clr_vec;
    logic              gie_q;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_ALM];

    alm_change_det #(.WIDTH(N_BITS), .STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (alarm_in),
        .change_o (change_all)
    );

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STAT_BASE + g);
        localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_BASE + g);
        assign stat_hit[g] = (reg_addr == A_ST);
        assign en_hit[g]   = (reg_addr == A_EN);
        assign clr_vec[g]  = reg_rd & stat_hit[g];

        alm_chan_status #(.NUM_ALM(NUM_ALM)) u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .change_i (change_all[g*NUM_ALM +: NUM_ALM]),
            .clr_i    (clr_vec[g]),
            .en_we_i  (reg_wr & en_hit[g]),
            .en_d_i   (reg_wdata[NUM_ALM-1:0]),
            .status_o (status_flat[g*NUM_ALM +: NUM_ALM]),
            .en_o     (en_flat[g*NUM_ALM +: NUM_ALM]),
            .pend_o   (pend_vec[g])
        );
    end

    // Global interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            gie_q <= 1'b0;
        else if (reg_wr && reg_addr == A_CTRL) gie_q <= reg_wdata[0];
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) reg_rdata[0] = gie_q;
        if (reg_addr == A_PEND) reg_rdata[NUM_CH-1:0] = pend_vec;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            if (stat_hit[c]) reg_rdata[NUM_ALM-1:0] = status_flat[c*NUM_ALM +: NUM_ALM];
            if (en_hit[c])   reg_rdata[NUM_ALM-1:0] = en_flat[c*NUM_ALM +: NUM_ALM];
        end
    end

    alm_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .gie_i    (gie_q),
        .pend_i   (pend_vec),
        .irq_n_o  (irq_n),
        .irq_oe_o (irq_oe)
    );
endmodule

// File: rtl/rx_alarm_irq_chk.sv
// Module: property checker for rx_alarm_irq_ctrl, attached by bind.
// Assumes the flattened status/enable/transition vectors of the top.
module rx_alarm_irq_chk #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_ALM = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_n,
    input logic                      irq_oe,
    input logic                      gie,
    input logic [NUM_CH*NUM_ALM-1:0] status_flat,
    input logic [NUM_CH*NUM_ALM-1:0] en_flat,
    input logic [NUM_CH*NUM_ALM-1:0] change_flat,
    input logic [NUM_CH-1:0]         clr_hit
);
    p_oe_inverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe != irq_n);

    p_gie_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> irq_n);

    p_needs_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((status_flat & en_flat) != '0));

    p_change_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (change_flat != '0) |=> ((status_flat & $past(change_flat)) == $past(change_flat)));

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && change_flat[g*NUM_ALM +: NUM_ALM] == '0)
            |=> (status_flat[g*NUM_ALM +: NUM_ALM] == '0));

        p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_hit[g] |=> ((status_flat[g*NUM_ALM +: NUM_ALM] & $past(status_flat[g*NUM_ALM +: NUM_ALM]))
                             == $past(status_flat[g*NUM_ALM +: NUM_ALM])));
    end
endmodule

bind rx_alarm_irq_ctrl rx_alarm_irq_chk #(.NUM_CH(NUM_CH), .NUM_ALM(NUM_ALM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_n       (irq_n),
    .irq_oe      (irq_oe),
    .gie         (gie_q),
    .status_flat (status_flat),
    .en_flat     (en_flat),
    .change_flat (change_all),
    .clr_hit     (clr_vec)
);

// File: tb/test_rx_alarm_irq_ctrl.sv
// Bench: directed corner cases plus seeded random stimulus, checked
// against a register-level model kept in bench variables.
module test_rx_alarm_irq_ctrl;
    localparam int NCH = 8;
    localparam int NA  = 4;
    localparam time CLK_P = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   alarm_in = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq_n;
    logic          irq_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [3:0] m_stat [NCH];
    logic [3:0] m_en   [NCH];
    logic       m_gie;
    logic [31:0] m_lvl;

    always #(CLK_P/2) clk = ~clk;

    rx_alarm_irq_ctrl i_rx_alarm_irq_ctrl (
        .clk, .rst_n, .alarm_in, .reg_wr, .reg_rd, .reg_addr,
        .reg_wdata, .reg_rdata, .irq_n, .irq_oe
    );

    function automatic logic [7:0] exp_pend();
        logic [7:0] p = '0;
        for (int c = 0; c < NCH; c++) p[c] = |(m_stat[c] & m_en[c]);
        return p;
    endfunction

    function automatic logic exp_irq_n();
        return !(m_gie && exp_pend() != 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 5'd0) m_gie = d[0];
        if (a >= 5'd10 && a <= 5'd17) m_en[a-10] = d[3:0];
    endtask

    task automatic do_rd(input logic [4:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #2;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        alarm_in = v;
        for (int c = 0; c < NCH; c++) m_stat[c] |= (m_lvl[c*NA +: NA] ^ v[c*NA +: NA]);
        m_lvl = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_stat(input int c, input string req);
        logic [7:0] d;
        do_rd(5'(2 + c), d);
        check(req, d, {4'b0, m_stat[c]});
        m_stat[c] = '0;
    endtask

    task automatic check_irq(input string req);
        check(req, {irq_n, irq_oe}, {exp_irq_n(), !exp_irq_n()});
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_0042));
        for (int c = 0; c < NCH; c++) begin m_stat[c] = '0; m_en[c] = '0; end
        m_gie = 1'b0; m_lvl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {irq_n, irq_oe}, 2'b10);
        do_rd(5'd0, d);  check("R1 ctrl", d, 0);
        do_rd(5'd1, d);  check("R1 pend", d, 0);
        do_rd(5'd17, d); check("R1 enable ch7", d, 0);
        // R11: idle inputs set nothing
        repeat (5) @(negedge clk);
        rd_stat(0, "R11 idle ch0");

        // R2: rising edge latency on ch3 alarm-indication (bit 13)
        do_wr(5'd0, 8'h01);
        do_wr(5'd13, 8'h0F);
        alarm_in[13] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 not before third edge", irq_n, 1'b1);
        @(negedge clk);
        check("R2 after third edge", irq_n, 1'b0);
        m_stat[3] = 4'b0010; m_lvl = alarm_in;
        rd_stat(3, "R2 status ch3");
        check_irq("R9 release after read");
        do_rd(5'd5, d); check("R4 second read", d, 0);

        // R3: falling edge
        drive(m_lvl & ~32'h0000_2000);
        check_irq("R3 irq on fall");
        rd_stat(3, "R3 status ch3");

        // R6: masked alarm latched but silent
        do_wr(5'd15, 8'h0E);
        drive(m_lvl | 32'h0010_0000);
        check_irq("R6 masked irq");
        do_rd(5'd1, d); check("R6 pend", d, exp_pend());
        rd_stat(5, "R6 masked status ch5");
        drive(m_lvl & ~32'h0010_0000);
        do_wr(5'd15, 8'h01);
        check_irq("R6 enabled irq");
        do_rd(5'd1, d); check("R8 pend first", d, 8'h20);
        do_rd(5'd1, d); check("R8 pend second", d, 8'h20);

        // R7: global enable off
        do_wr(5'd0, 8'h00);
        check("R7 gie off", irq_n, 1'b1);
        do_wr(5'd0, 8'h01);
        check("R7 gie on", irq_n, 1'b0);
        rd_stat(5, "R9 clear ch5");
        check_irq("R9 release");

        // R5: change coincides with clearing read on ch1 flat (bit 7)
        do_wr(5'd11, 8'h0F);
        alarm_in[7] = 1'b1; m_lvl = alarm_in;
        repeat (2) @(negedge clk);
        do_rd(5'd3, d); check("R5 read before latch", d, 0);
        m_stat[1] = 4'b1000;
        check_irq("R5 irq kept");
        rd_stat(1, "R5 change wins");

        // R10: writes to read-only and unmapped addresses
        drive(m_lvl | 32'h0000_0001);
        do_wr(5'd0, 8'h00);
        do_wr(5'd1, 8'hFF);
        do_wr(5'd2, 8'h00);
        do_wr(5'd31, 8'hFF);
        do_wr(5'd18, 8'hFF);
        do_rd(5'd31, d); check("R10 unmapped read", d, 0);
        do_rd(5'd0, d);  check("R10 ctrl kept", d, 0);
        do_rd(5'd10, d); check("R10 enable ch0 kept", d, 0);
        rd_stat(0, "R10 status kept");
        do_wr(5'd0, 8'h01);

        // Random phase: R2 R3 R6 R7 R8 R9 mixed
        for (int it = 0; it < 400; it++) begin
            int op;
            int c;
            op = $urandom_range(0, 4);
            c  = $urandom_range(0, NCH - 1);
            case (op)
                0: begin
                    logic [31:0] f = '0;
                    for (int k = 0; k < 3; k++) if ($urandom_range(0, 1) == 1) f[$urandom_range(0, 31)] = 1'b1;
                    drive(m_lvl ^ f);
                end
                1: rd_stat(c, "R2 R3 random status");
                2: do_wr(5'(10 + c), 8'($urandom_range(0, 255)));
                3: do_wr(5'd0, 8'($urandom_range(0, 3)));
                default: begin
                    do_rd(5'd1, d); check("R8 random pend", d, exp_pend());
                end
            endcase
            check_irq("R9 random irq");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule